// File: doc/BRIEF.md
# I2C Passive Bus Monitor

This block listens to the two wires of an I2C bus and turns the traffic it sees into single-cycle event pulses in the system clock domain. It never drives either line. Both lines pass through a synchronizer and a glitch filter. A small state machine then follows the transaction: the opening condition, the address byte, each acknowledge slot, the data bytes, repeated opening conditions and the closing condition.

Every completed byte comes out with an 8-bit value and a 2-bit class. The class is taken from the direction bit of the most recent address byte. Each sampled byte bit is also reported with its own strobe and value, so a downstream logger can rebuild the bit stream. A static configuration input chooses how address bytes are shown: as the 7-bit address, or as the raw byte with the direction bit still in place.

Top module: `i2c_bus_monitor`

## Requirements
- R1: After a synchronous active-low reset, all event pulses are low and the monitor waits for an opening condition.
- R2: When idle, SDA falling while SCL stays high gives one `start_o` pulse and begins an address byte.
- R3: Each SCL rising edge in the address or data phase gives one `bit_valid_o` pulse, with `bit_o` equal to SDA at that edge. Bytes are assembled MSB first from eight such samples.
- R4: On the eighth address bit, `byte_valid_o` pulses together with `bit_valid_o`. The class is 0 when the last bit is 1 (read) and 1 when it is 0 (write). The monitor then expects an acknowledge slot.
- R5: With `addr_raw_i` = 0 an address byte is reported as the byte shifted right by one. With `addr_raw_i` = 1 it is reported as the raw byte.
- R6: The SCL rising edge after a byte is the acknowledge slot. SDA low gives `ack_o` and SDA high gives `nack_o`, and no bit strobe. The monitor then enters the data phase.
- R7: Data bytes use class 2 when the held direction is read and class 3 when it is write. The byte value is the raw byte.
- R8: In the data phase, SDA falling while SCL is high gives `rstart_o` instead of `start_o`, and a new address byte follows.
- R9: In the data phase, SDA rising while SCL is high gives `stop_o` and returns to idle. It also clears the repeat flag, so the next opening condition is reported as `start_o`.
- R10: Line patterns that look like opening or closing conditions during the address phase, or while SCL is still high after the eighth bit, produce no event. The byte being decoded is unaffected.
- R11: A repeated opening condition partway through a data byte discards the partial bits. The next address byte then decodes correctly.
- R12: A pulse on either line shorter than `FILT_LEN` clock cycles is ignored.
- R13: While idle, SCL rising edges and SDA rising while SCL is high produce no event.
- R14: At most one of `start_o`, `rstart_o`, `stop_o`, `ack_o`, `nack_o`, `byte_valid_o` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line, asynchronous |
| addr_raw_i | input | 1 | 1: show the raw address byte, 0: show the 7-bit address |
| start_o | output | 1 | Opening condition pulse |
| rstart_o | output | 1 | Repeated opening condition pulse |
| stop_o | output | 1 | Closing condition pulse |
| ack_o | output | 1 | Acknowledge slot with SDA low |
| nack_o | output | 1 | Acknowledge slot with SDA high |
| bit_valid_o | output | 1 | Byte bit sampled |
| bit_o | output | 1 | Value of the sampled bit |
| byte_valid_o | output | 1 | Byte completed |
| byte_o | output | 8 | Byte value as reported |
| class_o | output | 2 | Byte class: 0 addr-read, 1 addr-write, 2 data-read, 3 data-write |

## Verification
The hardest case to reach is a condition-shaped SDA edge that must be ignored: it has to happen while SCL is high, either inside the address phase or in the gap after the eighth bit before SCL falls. The stimulus holds SCL high on chosen address bits and toggles SDA there. A related effect is that a repeated opening or closing condition issued from the data phase first raises SCL, so the monitor also reports one extra sampled bit. The bench models that extra bit explicitly. Sub-threshold pulses are inserted on SCL during its low phase and on SDA while the bus is idle. In both places an unfiltered pulse would create a bogus bit or opening condition.

// File: rtl/i2cmon_pkg.sv
// Package: shared types for the I2C passive bus monitor.
// Assumes an 8-bit byte and a 2-bit class code whose values are externally decoded.
package i2cmon_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned BCNT_W = $clog2(BYTE_W);

    // Decoder phase.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2,
        ST_ACK  = 2'd3
    } mon_state_e;

    // Byte class code; values are part of the output contract.
    typedef enum logic [1:0] {
        CLS_ADDR_RD = 2'd0,
        CLS_ADDR_WR = 2'd1,
        CLS_DATA_RD = 2'd2,
        CLS_DATA_WR = 2'd3
    } byte_class_e;

endpackage

// File: rtl/i2cmon_line_filter.sv
// Module: i2cmon_line_filter
// Synchronizes one asynchronous bus line and rejects pulses shorter than
// FILT_LEN clock cycles. The output changes only after the synchronized value
// has differed from it for FILT_LEN consecutive cycles.
// Assumes SYNC_STAGES >= 2 and FILT_LEN >= 1; reset value is the idle bus level.
module i2cmon_line_filter #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned FILT_LEN    = 3,
    parameter logic        RST_VAL     = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);

    localparam int unsigned CNT_W = $clog2(FILT_LEN + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILT_LEN - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CNT_W-1:0]       cnt_q;
    logic                   filt_q;
    logic                   sync_bit;

    assign sync_bit = sync_q[SYNC_STAGES-1];
    assign line_o   = filt_q;

    // Synchronizer chain into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= {SYNC_STAGES{RST_VAL}};
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
        end
    end

    // Persistence counter: accept a new level only after FILT_LEN agreeing cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            filt_q <= RST_VAL;
        end else if (sync_bit == filt_q) begin
            cnt_q <= '0;
        end else if (cnt_q == CNT_LAST) begin
            cnt_q  <= '0;
            filt_q <= sync_bit;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_FILT_FOLLOWS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(filt_q) |-> (filt_q == $past(sync_bit))); // R12

endmodule

// File: rtl/i2cmon_cond_detect.sv
// Module: i2cmon_cond_detect
// Registers the previous filtered SCL/SDA sample. It flags an SCL rising edge,
// an opening condition (SDA falls while SCL stays high) and a closing condition
// (SDA rises while SCL stays high). Both lines are compared against the same
// previous sample. Assumes filtered, clock-domain inputs.
module i2cmon_cond_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic start_cond_o,
    output logic stop_cond_o
);

    logic scl_prev_q;
    logic sda_prev_q;

    // Previous-sample register, reset to the idle bus level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_prev_q <= scl_i;
            sda_prev_q <= sda_i;
        end
    end

    // Edge and condition flags from current versus previous sample.
    always_comb begin
        scl_rise_o   = !scl_prev_q && scl_i;
        start_cond_o = scl_prev_q && scl_i && sda_prev_q && !sda_i;
        stop_cond_o  = scl_prev_q && scl_i && !sda_prev_q && sda_i;
    end

endmodule

// File: rtl/i2cmon_decoder.sv
// Module: i2cmon_decoder
// Transaction state machine. It assembles bytes MSB first, classifies them by
// the held direction, and reports the acknowledge slot and the opening and
// closing conditions as registered one-cycle pulses. Conditions are honoured
// only in the idle and data phases. Assumes single-cycle condition flags.
module i2cmon_decoder
    import i2cmon_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise_i,
    input  logic              start_cond_i,
    input  logic              stop_cond_i,
    input  logic              sda_i,
    input  logic              addr_raw_i,
    output logic              start_o,
    output logic              rstart_o,
    output logic              stop_o,
    output logic              ack_o,
    output logic              nack_o,
    output logic              bit_valid_o,
    output logic              bit_o,
    output logic              byte_valid_o,
    output logic [BYTE_W-1:0] byte_o,
    output byte_class_e       class_o
);

    localparam logic [BCNT_W-1:0] BIT_LAST = BCNT_W'(BYTE_W - 1);

    mon_state_e        state_q;
    logic [BCNT_W-1:0] cnt_q;
    logic [BYTE_W-1:0] shift_q;
    logic              dir_rd_q;
    logic              rep_q;

    logic [BYTE_W-1:0] shift_next;
    logic [BYTE_W-1:0] addr_shown;
    logic              last_bit;

    // Next shift value and address presentation.
    always_comb begin
        shift_next = {shift_q[BYTE_W-2:0], sda_i};
        addr_shown = addr_raw_i ? shift_next : {1'b0, shift_next[BYTE_W-1:1]};
        last_bit   = (cnt_q == BIT_LAST);
    end

    // Phase tracking, byte assembly and event pulse generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            cnt_q        <= '0;
            shift_q      <= '0;
            dir_rd_q     <= 1'b0;
            rep_q        <= 1'b0;
            start_o      <= 1'b0;
            rstart_o     <= 1'b0;
            stop_o       <= 1'b0;
            ack_o        <= 1'b0;
            nack_o       <= 1'b0;
            bit_valid_o  <= 1'b0;
            bit_o        <= 1'b0;
            byte_valid_o <= 1'b0;
            byte_o       <= '0;
            class_o      <= CLS_ADDR_RD;
        end else begin
            start_o      <= 1'b0;
            rstart_o     <= 1'b0;
            stop_o       <= 1'b0;
            ack_o        <= 1'b0;
            nack_o       <= 1'b0;
            bit_valid_o  <= 1'b0;
            byte_valid_o <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_cond_i) begin
                        start_o  <= !rep_q;
                        rstart_o <= rep_q;
                        rep_q    <= 1'b1;
                        dir_rd_q <= 1'b0;
                        cnt_q    <= '0;
                        shift_q  <= '0;
                        state_q  <= ST_ADDR;
                    end
                end
                ST_ADDR: begin
                    if (scl_rise_i) begin
                        bit_valid_o <= 1'b1;
                        bit_o       <= sda_i;
                        shift_q     <= shift_next;
                        if (last_bit) begin
                            cnt_q        <= '0;
                            byte_valid_o <= 1'b1;
                            byte_o       <= addr_shown;
                            class_o      <= sda_i ? CLS_ADDR_RD : CLS_ADDR_WR;
                            dir_rd_q     <= sda_i;
                            state_q      <= ST_ACK;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_rise_i) begin
                        ack_o   <= !sda_i;
                        nack_o  <= sda_i;
                        cnt_q   <= '0;
                        shift_q <= '0;
                        state_q <= ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (scl_rise_i) begin
                        bit_valid_o <= 1'b1;
                        bit_o       <= sda_i;
                        shift_q     <= shift_next;
                        if (last_bit) begin
                            cnt_q        <= '0;
                            byte_valid_o <= 1'b1;
                            byte_o       <= shift_next;
                            class_o      <= dir_rd_q ? CLS_DATA_RD : CLS_DATA_WR;
                            state_q      <= ST_ACK;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end else if (start_cond_i) begin
                        start_o  <= !rep_q;
                        rstart_o <= rep_q;
                        rep_q    <= 1'b1;
                        dir_rd_q <= 1'b0;
                        cnt_q    <= '0;
                        shift_q  <= '0;
                        state_q  <= ST_ADDR;
                    end else if (stop_cond_i) begin
                        stop_o   <= 1'b1;
                        rep_q    <= 1'b0;
                        dir_rd_q <= 1'b0;
                        cnt_q    <= '0;
                        shift_q  <= '0;
                        state_q  <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    AST_EVENT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_o, rstart_o, stop_o, ack_o, nack_o, byte_valid_o})); // R14
    AST_BYTE_HAS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid_o |-> bit_valid_o); // R3
    AST_BYTE_TO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid_o |-> (state_q == ST_ACK)); // R4
    AST_ACK_TO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o || nack_o) |-> (state_q == ST_DATA)); // R6
    AST_DATA_CLASS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid_o && class_o[1]) |-> ($past(state_q) == ST_DATA)); // R7
    AST_RSTART_FROM_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        rstart_o |-> ($past(state_q) == ST_DATA)); // R8
    AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o |-> (state_q == ST_IDLE && !rep_q)); // R9
    AST_NO_COND_IN_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_ADDR || $past(state_q) == ST_ACK)
            |-> !(start_o || rstart_o || stop_o)); // R10

endmodule

// File: rtl/i2c_bus_monitor.sv
// Module: i2c_bus_monitor (top)
// Passive I2C monitor: per-line synchronizer and glitch filter, condition
// detector, then the transaction decoder. All event outputs are registered.
// Assumes scl_i/sda_i are asynchronous and that the block never drives the bus.
module i2c_bus_monitor #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned FILT_LEN    = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic       addr_raw_i,
    output logic       start_o,
    output logic       rstart_o,
    output logic       stop_o,
    output logic       ack_o,
    output logic       nack_o,
    output logic       bit_valid_o,
    output logic       bit_o,
    output logic       byte_valid_o,
    output logic [7:0] byte_o,
    output logic [1:0] class_o
);

    import i2cmon_pkg::*;

    localparam int unsigned N_LINES = 2;

    logic [N_LINES-1:0] raw_lines;
    logic [N_LINES-1:0] filt_lines;
    logic               scl_rise;
    logic               start_cond;
    logic               stop_cond;
    byte_class_e        class_w;

    assign raw_lines = {sda_i, scl_i};
    assign class_o   = class_w;

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        i2cmon_line_filter #(
            .SYNC_STAGES (SYNC_STAGES),
            .FILT_LEN    (FILT_LEN),
            .RST_VAL     (1'b1)
        ) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (raw_lines[g]),
            .line_o (filt_lines[g])
        );
    end

    i2cmon_cond_detect u_cond (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (filt_lines[0]),
        .sda_i        (filt_lines[1]),
        .scl_rise_o   (scl_rise),
        .start_cond_o (start_cond),
        .stop_cond_o  (stop_cond)
    );

    i2cmon_decoder u_dec (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_rise_i   (scl_rise),
        .start_cond_i (start_cond),
        .stop_cond_i  (stop_cond),
        .sda_i        (filt_lines[1]),
        .addr_raw_i   (addr_raw_i),
        .start_o      (start_o),
        .rstart_o     (rstart_o),
        .stop_o       (stop_o),
        .ack_o        (ack_o),
        .nack_o       (nack_o),
        .bit_valid_o  (bit_valid_o),
        .bit_o        (bit_o),
        .byte_valid_o (byte_valid_o),
        .byte_o       (byte_o),
        .class_o      (class_w)
    );

endmodule

// File: tb/test_i2c_bus_monitor.sv
// Scoreboard bench: driver tasks push expected events, a monitor pops and compares.
module test_i2c_bus_monitor;

    localparam int W = 12;   // cycles per bus phase, above the filter latency

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_r = 1'b1;
    logic sda_r = 1'b1;
    logic raw_r = 1'b0;
    logic start_o, rstart_o, stop_o, ack_o, nack_o, bit_valid_o, bit_o, byte_valid_o;
    logic [7:0] byte_o;
    logic [1:0] class_o;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    // Event kinds: 0 start, 1 rstart, 2 stop, 3 ack, 4 nack, 5 bit, 6 byte(class*256+value)
    int    q_kind[$];
    int    q_val[$];
    string q_req[$];

    always #10 clk = ~clk;   // 50 MHz

    i2c_bus_monitor i_i2c_bus_monitor (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_r), .sda_i(sda_r), .addr_raw_i(raw_r),
        .start_o(start_o), .rstart_o(rstart_o), .stop_o(stop_o), .ack_o(ack_o),
        .nack_o(nack_o), .bit_valid_o(bit_valid_o), .bit_o(bit_o),
        .byte_valid_o(byte_valid_o), .byte_o(byte_o), .class_o(class_o)
    );

    task automatic exp(int k, int v, string req);
        q_kind.push_back(k);
        q_val.push_back(v);
        q_req.push_back(req);
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(bit ok, string req, string what, int act, int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic got(int k, int v);
        if (q_kind.size() == 0) begin
            check(1'b0, "R14", "unexpected event kind", k, -1);
        end else begin
            int    ek = q_kind.pop_front();
            int    ev = q_val.pop_front();
            string er = q_req.pop_front();
            check(ek == k, er, "event kind", k, ek);
            if (ek == k) check(ev == v, er, "event value", v, ev);
        end
    endtask

    // Monitor: compares every produced event against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (start_o)      got(0, 0);
            if (rstart_o)     got(1, 0);
            if (stop_o)       got(2, 0);
            if (ack_o)        got(3, 0);
            if (nack_o)       got(4, 0);
            if (bit_valid_o)  got(5, int'(bit_o));
            if (byte_valid_o) got(6, int'(class_o) * 256 + int'(byte_o));
        end
    end

    task automatic drive_bit(bit b, bit cond, bit glitch);
        sda_r = b;
        wait_n(W);
        scl_r = 1'b1;
        wait_n(W);
        if (cond) begin
            sda_r = !b;
            wait_n(W);
            sda_r = b;
            wait_n(W);
        end
        scl_r = 1'b0;
        wait_n(W);
        if (glitch) begin
            scl_r = 1'b1;
            wait_n(1);
            scl_r = 1'b0;
            wait_n(W);
        end
    endtask

    // Byte: expects 8 bits then the byte event; cmask/gmask pick bits with condition patterns or SCL glitches.
    task automatic send_byte(bit [7:0] b, int cls, int shown, bit [7:0] cmask, bit [7:0] gmask, string req);
        for (int i = 7; i >= 0; i--) exp(5, int'(b[i]), "R3");
        exp(6, cls * 256 + shown, req);
        for (int i = 7; i >= 0; i--) drive_bit(b[i], cmask[i], gmask[i]);
    endtask

    task automatic send_addr(bit [7:0] b, bit [7:0] cmask, bit [7:0] gmask, string req);
        int cls = b[0] ? 0 : 1;
        int shown = raw_r ? int'(b) : int'(b >> 1);
        send_byte(b, cls, shown, cmask, gmask, req);
    endtask

    task automatic send_ack(bit nk, string req);
        exp(nk ? 4 : 3, 0, req);
        drive_bit(nk, 1'b0, 1'b0);
    endtask

    task automatic send_start(bit rep, string req);
        if (rep) exp(5, 1, "R3");
        exp(rep ? 1 : 0, 0, req);
        sda_r = 1'b1; wait_n(W);
        scl_r = 1'b1; wait_n(W);
        sda_r = 1'b0; wait_n(W);
        scl_r = 1'b0; wait_n(W);
    endtask

    task automatic send_stop(string req);
        exp(5, 0, "R3");
        exp(2, 0, req);
        sda_r = 1'b0; wait_n(W);
        scl_r = 1'b1; wait_n(W);
        sda_r = 1'b1; wait_n(W);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            tests++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        wait_n(5);
        rst_n = 1'b1;
        wait_n(1);
        // R1: reset state
        check(!(start_o | rstart_o | stop_o), "R1", "conditions after reset", 1, 0);
        check(!(ack_o | nack_o), "R1", "ack pulses after reset", 1, 0);
        check(!(bit_valid_o | byte_valid_o), "R1", "strobes after reset", 1, 0);
        wait_n(W);

        // Write transaction, shifted address form (R2, R4, R5, R6, R7, R9)
        raw_r = 1'b0;
        send_start(1'b0, "R2");
        send_addr(8'hA0, 8'h00, 8'h00, "R4 R5");
        send_ack(1'b0, "R6");
        send_byte(8'h3C, 3, 8'h3C, 8'h00, 8'h00, "R7");
        send_ack(1'b1, "R6");
        send_stop("R9");

        // Write address then repeated start to a read (R8, R7, R9)
        send_start(1'b0, "R9");
        send_addr(8'hA2, 8'h00, 8'h00, "R4");
        send_ack(1'b0, "R6");
        send_start(1'b1, "R8");
        send_addr(8'hA3, 8'h00, 8'h00, "R4");
        send_ack(1'b0, "R6");
        send_byte(8'h96, 2, 8'h96, 8'h00, 8'h00, "R7");
        send_ack(1'b1, "R6");
        send_stop("R9");

        // Raw address form (R5)
        raw_r = 1'b1;
        send_start(1'b0, "R2");
        send_addr(8'hA3, 8'h00, 8'h00, "R5");
        send_ack(1'b0, "R6");
        send_stop("R9");
        raw_r = 1'b0;

        // Condition patterns inside address phase and after 8th bit (R10)
        send_start(1'b0, "R2");
        send_addr(8'hA2, 8'h11, 8'h00, "R10");
        send_ack(1'b0, "R6");
        send_stop("R9");

        // Cut-short data byte (R11)
        send_start(1'b0, "R2");
        send_addr(8'h90, 8'h00, 8'h00, "R4");
        send_ack(1'b0, "R6");
        exp(5, 1, "R11"); exp(5, 0, "R11"); exp(5, 1, "R11");
        drive_bit(1'b1, 1'b0, 1'b0);
        drive_bit(1'b0, 1'b0, 1'b0);
        drive_bit(1'b1, 1'b0, 1'b0);
        send_start(1'b1, "R11");
        send_addr(8'h6B, 8'h00, 8'h00, "R11");
        send_ack(1'b0, "R6");
        send_byte(8'h01, 2, 8'h01, 8'h00, 8'h00, "R7");
        send_ack(1'b0, "R6");
        send_stop("R9");

        // Glitches: SDA in idle, SCL during address low phases (R12)
        sda_r = 1'b0; wait_n(1); sda_r = 1'b1; wait_n(W);
        sda_r = 1'b0; wait_n(2); sda_r = 1'b1; wait_n(W);
        send_start(1'b0, "R12");
        send_addr(8'hA3, 8'h00, 8'h24, "R12");
        send_ack(1'b0, "R6");
        send_stop("R9");

        // Idle activity with no opening condition (R13)
        scl_r = 1'b0; wait_n(W);
        sda_r = 1'b0; wait_n(W);
        scl_r = 1'b1; wait_n(W);
        sda_r = 1'b1; wait_n(W);
        scl_r = 1'b0; wait_n(W);
        scl_r = 1'b1; wait_n(W);
        send_start(1'b0, "R13");
        send_addr(8'h42, 8'h00, 8'h00, "R13");
        send_ack(1'b1, "R6");
        send_stop("R9");

        wait_n(4 * W);
        done = 1'b1;
        check(q_kind.size() == 0, "R14", "pending expected events", q_kind.size(), 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule